// File: doc/BRIEF.md
# Flash Write Qualifier with Secured-Region Read Overlay

This block is the bus front end of a small NOR-style flash model. It takes the three active-low bus strobes (chip enable, write enable, output enable) from outside the system clock domain. It synchronizes and de-glitches them, then decides which bus cycles are genuine writes. A qualified write appears as a single-cycle pulse, together with the address and data captured during the write, for the command decoder that follows. A write is refused when the strobe combination forbids it, when the supply flag reports a lockout, or when the strobes were already in a write state at power-up or at the end of a lockout.

The block also keeps a sticky overlay flag. An enter command moves reads onto a 256-byte secured region, and the reads stay there until an exit command, a hardware reset or a supply loss. While the overlay is set, the read address sent to storage is cut down to a region offset: 8 bits in byte mode, 7 bits in word mode. A separate flag marks the serial-number part at the start of the region. A factory-lock indicator is a fixed read-only output.

Top module: `flash_front_ctl`

## Requirements
- R1: While rst_ni is low, wr_valid_o is 0, sec_sel_o is 0 and cmd_rst_o is 1.
- R2: When ce_ni=0 and oe_ni=1 are held, a low pulse of two or more clocks on we_ni produces exactly one wr_valid_o pulse after we_ni rises. wr_addr_o and wr_data_o then carry the addr_i and data_i values that were held during the cycle.
- R3: If oe_ni=0 or ce_ni=1 is held during a we_ni low pulse, no wr_valid_o pulse occurs.
- R4: A low pulse on we_ni that lasts one clock period produces no wr_valid_o pulse.
- R5: While supply_ok_i=0, no wr_valid_o pulse occurs and cmd_rst_o is 1 from the next cycle on.
- R6: If the strobes are already in the write state (ce_ni=0, we_ni=0, oe_ni=1) when reset is released or when supply_ok_i returns to 1, the next rising edge of we_ni is not accepted. Writes are accepted again once we_ni has been seen high.
- R7: A one-cycle enter_cmd_i pulse sets sec_sel_o to 1 from the next cycle. An exit_cmd_i pulse clears it from the next cycle. If both arrive in the same cycle, exit wins.
- R8: sec_sel_o is cleared by rst_ni low and, one cycle later, by supply_ok_i=0.
- R9: With sec_sel_o=0, rd_addr_o equals addr_i. With sec_sel_o=1, rd_addr_o is addr_i[7:0] zero-extended when byte_mode_i=1, and addr_i[6:0] zero-extended when byte_mode_i=0.
- R10: sn_zone_o is 1 only when sec_sel_o=1 and the region offset is below 16 in byte mode or below 8 in word mode.
- R11: factory_lock_o is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| supply_ok_i | input | 1 | 1 when the supply is above the lockout threshold |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | AW (20) | Bus address |
| data_i | input | DW (16) | Bus write data |
| byte_mode_i | input | 1 | 1 selects byte addressing, 0 selects word addressing |
| enter_cmd_i | input | 1 | One-cycle pulse: enter the secured-region overlay |
| exit_cmd_i | input | 1 | One-cycle pulse: leave the secured-region overlay |
| wr_valid_o | output | 1 | One-cycle pulse for each qualified write |
| wr_addr_o | output | AW (20) | Address captured for the qualified write |
| wr_data_o | output | DW (16) | Data captured for the qualified write |
| cmd_rst_o | output | 1 | Holds the command register and program/erase control in reset |
| sec_sel_o | output | 1 | Reads are directed to the secured region |
| rd_addr_o | output | AW (20) | Read address sent to the storage model |
| sn_zone_o | output | 1 | The read falls in the serial-number part of the region |
| factory_lock_o | output | 1 | Read-only factory-lock indicator |

## Verification
Any fault in the strobe filter or in the arming state shows at the ports as a missing or extra wr_valid_o pulse. It shows within a few cycles of the rising edge of we_ni, so the bench counts pulses for each bus cycle, under random strobe combinations and pulse widths. A wrong overlay flag shows one cycle after the command, on sec_sel_o, rd_addr_o and sn_zone_o. The bench therefore checks reads under random addresses and both addressing modes, in both overlay states. Directed cases cover the power-up and lockout-recovery traps: there, an arming flag that is never cleared produces a write that should have been refused.

// File: rtl/flash_front_pkg.sv
package flash_front_pkg;
  localparam int unsigned N_STROBE = 3;
  localparam int unsigned STB_CE = 0;
  localparam int unsigned STB_WE = 1;
  localparam int unsigned STB_OE = 2;

  typedef struct packed {
    logic oe_n;
    logic we_n;
    logic ce_n;
  } strobe_t;
endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 2,
  parameter logic        RST_VAL     = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;
  logic                   s;

  assign s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (s == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        // level held long enough: accept it
        filt_q <= s;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/write_qual.sv
module write_qual #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  flash_front_pkg::strobe_t stb_i,
  input  logic                    supply_ok_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           data_i,
  output logic                    wr_valid_o,
  output logic [AW-1:0]           wr_addr_o,
  output logic [DW-1:0]           wr_data_o,
  output logic                    cmd_rst_o
);
  logic act, act_q, armed_q, valid_q, cmd_rst_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = !stb_i.ce_n && !stb_i.we_n && stb_i.oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      armed_q   <= 1'b0;
      valid_q   <= 1'b0;
      cmd_rst_q <= 1'b1;
    end else begin
      cmd_rst_q <= !supply_ok_i;
      // rising write enable closes a write; needs arming from an earlier idle
      valid_q   <= supply_ok_i && armed_q && act_q && stb_i.we_n;
      act_q     <= supply_ok_i && act;
      armed_q   <= supply_ok_i && (armed_q || stb_i.we_n);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (act) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign wr_valid_o = valid_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;
  assign cmd_rst_o  = cmd_rst_q;
endmodule

// File: rtl/region_steer.sv
module region_steer #(
  parameter int unsigned AW           = 20,
  parameter int unsigned REGION_BYTES = 256,
  parameter int unsigned SN_BYTES     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_ok_i,
  input  logic          enter_i,
  input  logic          exit_i,
  input  logic          byte_mode_i,
  input  logic [AW-1:0] addr_i,
  output logic          sec_sel_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          sn_zone_o
);
  localparam int unsigned BAW = $clog2(REGION_BYTES);
  localparam int unsigned WAW = BAW - 1;
  localparam int unsigned SN_WORDS = SN_BYTES / 2;

  logic          sec_q;
  logic [AW-1:0] off_b, off_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sec_q <= 1'b0;
    else if (!supply_ok_i) sec_q <= 1'b0;
    else if (exit_i)      sec_q <= 1'b0;
    else if (enter_i)     sec_q <= 1'b1;
  end

  assign off_b = AW'(addr_i[BAW-1:0]);
  assign off_w = AW'(addr_i[WAW-1:0]);

  always_comb begin
    rd_addr_o = addr_i;
    sn_zone_o = 1'b0;
    if (sec_q) begin
      if (byte_mode_i) begin
        rd_addr_o = off_b;
        sn_zone_o = off_b < AW'(SN_BYTES);
      end else begin
        rd_addr_o = off_w;
        sn_zone_o = off_w < AW'(SN_WORDS);
      end
    end
  end

  assign sec_sel_o = sec_q;
endmodule

// File: rtl/flash_front_ctl.sv
module flash_front_ctl #(
  parameter int unsigned AW           = 20,
  parameter int unsigned DW           = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_CYC     = 2,
  parameter int unsigned REGION_BYTES = 256,
  parameter int unsigned SN_BYTES     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_ok_i,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          byte_mode_i,
  input  logic          enter_cmd_i,
  input  logic          exit_cmd_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          cmd_rst_o,
  output logic          sec_sel_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          sn_zone_o,
  output logic          factory_lock_o
);
  import flash_front_pkg::*;

  logic [N_STROBE-1:0] raw, filt;
  strobe_t             stb;

  assign raw[STB_CE] = ce_ni;
  assign raw[STB_WE] = we_ni;
  assign raw[STB_OE] = oe_ni;

  for (genvar g = 0; g < N_STROBE; g++) begin : g_stb
    strobe_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC),
      .RST_VAL    (1'b0)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  assign stb.ce_n = filt[STB_CE];
  assign stb.we_n = filt[STB_WE];
  assign stb.oe_n = filt[STB_OE];

  write_qual #(.AW(AW), .DW(DW)) u_wq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb),
    .supply_ok_i(supply_ok_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .cmd_rst_o  (cmd_rst_o)
  );

  region_steer #(
    .AW          (AW),
    .REGION_BYTES(REGION_BYTES),
    .SN_BYTES    (SN_BYTES)
  ) u_rs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .enter_i    (enter_cmd_i),
    .exit_i     (exit_cmd_i),
    .byte_mode_i(byte_mode_i),
    .addr_i     (addr_i),
    .sec_sel_o  (sec_sel_o),
    .rd_addr_o  (rd_addr_o),
    .sn_zone_o  (sn_zone_o)
  );

  assign factory_lock_o = 1'b1;
endmodule

// File: rtl/flash_front_chk.sv
module flash_front_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          supply_ok_i,
  input logic          enter_cmd_i,
  input logic          exit_cmd_i,
  input logic          byte_mode_i,
  input logic          wr_valid_o,
  input logic          cmd_rst_o,
  input logic          sec_sel_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          sn_zone_o
);
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  assert_lockout_nowrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !wr_valid_o);

  assert_lockout_cmdrst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> cmd_rst_o);

  assert_exit_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_cmd_i |=> !sec_sel_o);

  assert_enter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_cmd_i && !exit_cmd_i && supply_ok_i) |=> sec_sel_o);

  assert_supply_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !sec_sel_o);

  assert_byte_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_sel_o && byte_mode_i) |-> ((rd_addr_o >> 8) == '0));

  assert_word_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_sel_o && !byte_mode_i) |-> ((rd_addr_o >> 7) == '0));

  assert_zone_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sn_zone_o |-> (sec_sel_o && ((rd_addr_o >> 4) == '0)));
endmodule

bind flash_front_ctl flash_front_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .enter_cmd_i(enter_cmd_i),
  .exit_cmd_i (exit_cmd_i),
  .byte_mode_i(byte_mode_i),
  .wr_valid_o (wr_valid_o),
  .cmd_rst_o  (cmd_rst_o),
  .sec_sel_o  (sec_sel_o),
  .rd_addr_o  (rd_addr_o),
  .sn_zone_o  (sn_zone_o)
);

// File: tb/flash_front_ctl_tb_top.sv
module flash_front_ctl_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic byte_mode = 1'b1, enter = 1'b0, exitc = 1'b0;
  logic wr_valid, cmd_rst, sec_sel, sn_zone, flock;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_err = 0;
  int pulses = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  logic done = 1'b0;

  always #10 clk = ~clk;

  flash_front_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .byte_mode_i(byte_mode),
    .enter_cmd_i(enter), .exit_cmd_i(exitc),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .cmd_rst_o(cmd_rst), .sec_sel_o(sec_sel), .rd_addr_o(rd_addr),
    .sn_zone_o(sn_zone), .factory_lock_o(flock)
  );

  always @(posedge clk) if (rst_ni && wr_valid) begin
    pulses++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_rd(input logic [AW-1:0] a, input logic bm, input logic sec);
    if (!sec) return a;
    return bm ? AW'(a[7:0]) : AW'(a[6:0]);
  endfunction

  function automatic logic exp_zone(input logic [AW-1:0] a, input logic bm, input logic sec);
    if (!sec) return 1'b0;
    return bm ? (a[7:0] < 8'd16) : (a[6:0] < 7'd8);
  endfunction

  task automatic bus_wr(input logic ce_v, input logic oe_v, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int lowc, input string req);
    int p0;
    bit exp;
    @(negedge clk);
    ce_n = ce_v; oe_n = oe_v; addr = a; data = d;
    repeat (4) @(negedge clk);
    p0 = pulses;
    we_n = 1'b0;
    repeat (lowc) @(negedge clk);
    we_n = 1'b1;
    repeat (8) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (6) @(negedge clk);
    exp = supply_ok && !ce_v && oe_v && (lowc >= 2);
    chk((pulses - p0) == int'(exp), req, pulses - p0, int'(exp));
    if (exp) begin
      chk(last_a == a, "R2 addr", last_a, a);
      chk(last_d == d, "R2 data", last_d, d);
    end
  endtask

  task automatic pulse_cmd(input logic en, input logic ex);
    @(negedge clk); enter = en; exitc = ex;
    @(negedge clk); enter = 1'b0; exitc = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !sec_sel && cmd_rst, "R1 reset state", {wr_valid, sec_sel, cmd_rst}, 3'b001);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int p0;
    void'($urandom(32'h5eed));
    do_reset();
    chk(flock == 1'b1, "R11 lock bit", flock, 1);

    // R2 directed, minimum width
    bus_wr(1'b0, 1'b1, 20'h12345, 16'hbeef, 2, "R2 min width");
    // R4 glitch
    bus_wr(1'b0, 1'b1, 20'h00aaa, 16'h1111, 1, "R4 glitch");
    // R3 logical inhibit
    bus_wr(1'b0, 1'b0, 20'h00bbb, 16'h2222, 4, "R3 oe low");
    bus_wr(1'b1, 1'b1, 20'h00ccc, 16'h3333, 4, "R3 ce high");

    // R5 lockout
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    chk(cmd_rst == 1'b1, "R5 cmd reset", cmd_rst, 1);
    bus_wr(1'b0, 1'b1, 20'h00ddd, 16'h4444, 4, "R5 lockout write");
    @(negedge clk); supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_rst == 1'b0, "R5 cmd reset release", cmd_rst, 0);

    // R6 lockout recovery with strobes held in write state
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (5) @(negedge clk); supply_ok = 1'b0;
    repeat (5) @(negedge clk); supply_ok = 1'b1;
    repeat (6) @(negedge clk);
    p0 = pulses;
    we_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(pulses == p0, "R6 lockout first edge", pulses - p0, 0);
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_wr(1'b0, 1'b1, 20'h00eee, 16'h5555, 3, "R6 resume after lockout");

    // R6 power-up with strobes in write state
    rst_ni = 1'b0;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    p0 = pulses;
    we_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(pulses == p0, "R6 power-up first edge", pulses - p0, 0);
    ce_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_wr(1'b0, 1'b1, 20'h00fff, 16'h6666, 3, "R6 resume after power-up");

    // R7 overlay
    pulse_cmd(1'b1, 1'b0);
    chk(sec_sel == 1'b1, "R7 enter", sec_sel, 1);
    pulse_cmd(1'b0, 1'b1);
    chk(sec_sel == 1'b0, "R7 exit", sec_sel, 0);
    pulse_cmd(1'b1, 1'b1);
    chk(sec_sel == 1'b0, "R7 exit wins", sec_sel, 0);
    pulse_cmd(1'b1, 1'b0);
    pulse_cmd(1'b1, 1'b0);
    chk(sec_sel == 1'b1, "R7 sticky", sec_sel, 1);

    // R8 supply loss and reset
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk); supply_ok = 1'b1;
    @(negedge clk);
    chk(sec_sel == 1'b0, "R8 supply loss", sec_sel, 0);
    pulse_cmd(1'b1, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk(sec_sel == 1'b0, "R8 hw reset", sec_sel, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (6) @(negedge clk);

    // R9/R10 directed boundaries
    pulse_cmd(1'b1, 1'b0);
    @(negedge clk); byte_mode = 1'b1; addr = 20'hfff0f;
    #1 chk(sn_zone && rd_addr == 20'h0f, "R10 byte last sn", {sn_zone, rd_addr}, 21'h10000f);
    addr = 20'h00010;
    #1 chk(!sn_zone, "R10 byte first user", sn_zone, 0);
    byte_mode = 1'b0; addr = 20'h00007;
    #1 chk(sn_zone, "R10 word last sn", sn_zone, 1);
    addr = 20'h00088;
    #1 chk(!sn_zone && rd_addr == 20'h08, "R9 word wrap", rd_addr, 20'h08);

    // random reads in both overlay states
    for (int i = 0; i < 200; i++) begin
      logic sec_e;
      if (i % 50 == 0) pulse_cmd((i / 50) % 2 == 0, (i / 50) % 2 == 1);
      sec_e = ((i / 50) % 2 == 0);
      @(negedge clk);
      addr = AW'($urandom);
      byte_mode = 1'($urandom);
      #1;
      chk(rd_addr == exp_rd(addr, byte_mode, sec_e), "R9 steer", rd_addr, exp_rd(addr, byte_mode, sec_e));
      chk(sn_zone == exp_zone(addr, byte_mode, sec_e), "R10 zone", sn_zone, exp_zone(addr, byte_mode, sec_e));
    end
    pulse_cmd(1'b0, 1'b1);

    // random bus cycles
    for (int i = 0; i < 150; i++) begin
      logic ce_r, oe_r;
      int lc;
      ce_r = ($urandom % 4) == 0;
      oe_r = ($urandom % 4) != 0;
      lc = 1 + int'($urandom % 4);
      bus_wr(ce_r, oe_r, AW'($urandom), DW'($urandom), lc, "R2/R3/R4 random");
    end
    chk(flock == 1'b1, "R11 lock bit end", flock, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule